// File: doc/BRIEF.md
# Segment Limit and Translation Checker

This block is the address stage that comes right after segmentation. It takes a virtual address that already includes the segment base, together with:

- the access size and the kind of access;
- the current mode bits;
- the attributes of the selected segment.

It decides whether the access violates the segment's permissions or bounds. When the access is allowed, it forms the physical address. With paging on, that address comes from a translation entry supplied by an external lookup; with paging off, the incoming address passes straight through.

Every request with `req_valid` high gives one response on the next clock. The response is one of three outcomes:

- a general-protection fault;
- a translation-miss fault;
- a physical address.

Real mode bypasses every check. 64-bit code bypasses only the segment checks.

The end of an access is computed one bit wider than the address. An access that runs past the top of the address space is therefore never treated as a small end value.

Top module: `seg_xlate_check`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `rsp_valid`, `rsp_gp`, `rsp_miss` and `rsp_paddr` are all zero.
- R2: A request accepted with `req_valid` high produces `rsp_valid` high on the following clock. A cycle with `req_valid` low produces `rsp_valid`, `rsp_gp` and `rsp_miss` low on the following clock.
- R3: With `mode_prot` low, `rsp_paddr` equals `req_addr` and neither fault is raised, whatever the segment, paging and hit inputs are.
- R4: Segment checks are skipped only when `mode_lma` and `mode_cs64` are both high. Either bit alone still enforces them.
- R5: `req_kind` is 2'b00 read, 2'b01 write, 2'b10 instruction fetch (2'b11 behaves as read). A write to a segment with `seg_wr` low is a GP fault. A read with `seg_rd` low is a GP fault. A fetch ignores `seg_rd`.
- R6: Let end = `req_addr` + `req_size`, computed one bit wider than the address. For an expand-up segment with `seg_limit` >= `seg_base`, the access faults when `seg_limit` < end.
- R7: For an expand-up segment with `seg_limit` < `seg_base`, the access faults only when `seg_limit` < end and `req_addr` < `seg_base`.
- R8: For an expand-down segment with `seg_limit` < `seg_base`, the access faults when `req_addr` <= `seg_limit`, or when end >= `seg_base`.
- R9: For an expand-down segment with `seg_limit` >= `seg_base`, the access faults when `req_addr` <= `seg_limit` and also end >= `seg_base`.
- R10: With `mode_prot` and `mode_paging` high and `tlb_hit` high, `rsp_paddr` = `tlb_frame` OR the low 12 bits of `req_addr`.
- R11: With `mode_prot` and `mode_paging` high and `tlb_hit` low, `rsp_miss` is raised. With `mode_prot` high and `mode_paging` low, `rsp_paddr` equals `req_addr` and `rsp_miss` stays low.
- R12: `rsp_gp` and `rsp_miss` are never high together, and a GP fault wins over a miss. `rsp_paddr` is zero whenever a fault is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | AW | Segment-applied virtual address |
| req_size | input | SW | Access size in bytes |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| mode_prot | input | 1 | Protection enabled |
| mode_paging | input | 1 | Paging enabled |
| mode_lma | input | 1 | Long mode active |
| mode_cs64 | input | 1 | Code segment is 64-bit |
| seg_rd | input | 1 | Segment readable |
| seg_wr | input | 1 | Segment writable |
| seg_expdn | input | 1 | Segment grows down |
| seg_base | input | AW | Segment base |
| seg_limit | input | AW | Segment limit |
| tlb_hit | input | 1 | Lookup hit for this address |
| tlb_frame | input | AW | Physical page address from the lookup |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | AW | Physical address, zero on fault |
| rsp_gp | output | 1 | General-protection fault |
| rsp_miss | output | 1 | Translation-miss fault |

## Verification
Two things can occur in the same cycle: a segment or permission violation, and a translation miss. This happens whenever paging is on, the lookup misses, and the access also breaks its segment rules. The bench provokes it with a write to a read-only segment while paging is on and the hit input is low. It then requires `rsp_gp` alone, with `rsp_miss` low and a zero address. An assertion also watches every response for the two fault flags being high together.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    localparam int PAGE_OFFSET_BITS = 12;

endpackage

// File: rtl/seg_perm_check.sv
module seg_perm_check
    import seg_xlate_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       seg_rd,
    input  logic       seg_wr,
    output logic       perm_fail
);
    acc_kind_e kind_e;

    always_comb begin
        kind_e = acc_kind_e'(kind);
        unique case (kind_e)
            ACC_WRITE: perm_fail = !seg_wr;
            ACC_FETCH: perm_fail = 1'b0;
            default:   perm_fail = !seg_rd;
        endcase
    end
endmodule

// File: rtl/seg_bound_check.sv
module seg_bound_check #(
    parameter int AW = 32,
    parameter int SW = 4
) (
    input  logic [AW-1:0] addr,
    input  logic [SW-1:0] size,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    input  logic          expdn,
    output logic          bound_fail
);
    localparam int EW = AW + 1;

    logic [EW-1:0] end_w;
    logic [EW-1:0] addr_w;
    logic [EW-1:0] base_w;
    logic [EW-1:0] limit_w;
    logic          wrapped;

    always_comb begin
        addr_w  = {1'b0, addr};
        base_w  = {1'b0, base};
        limit_w = {1'b0, limit};
        end_w   = addr_w + EW'(size);
        wrapped = limit_w < base_w;
        if (!expdn) begin
            if (wrapped) bound_fail = (limit_w < end_w) && (addr_w < base_w);
            else         bound_fail = (limit_w < end_w);
        end else begin
            if (wrapped) bound_fail = (addr_w <= limit_w) || (end_w >= base_w);
            else         bound_fail = (addr_w <= limit_w) && (end_w >= base_w);
        end
    end
endmodule

// File: rtl/page_compose.sv
module page_compose #(
    parameter int AW = 32,
    parameter int PB = 12
) (
    input  logic          paging_on,
    input  logic          hit,
    input  logic [AW-1:0] frame,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] paddr,
    output logic          miss
);
    localparam int HB = AW - PB;

    logic [AW-1:0] offset_w;

    always_comb begin
        offset_w = {{HB{1'b0}}, addr[PB-1:0]};
        paddr    = paging_on ? (frame | offset_w) : addr;
        miss     = paging_on && !hit;
    end
endmodule

// File: rtl/seg_xlate_check.sv
module seg_xlate_check
    import seg_xlate_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [SW-1:0] req_size,
    input  logic [1:0]    req_kind,
    input  logic          mode_prot,
    input  logic          mode_paging,
    input  logic          mode_lma,
    input  logic          mode_cs64,
    input  logic          seg_rd,
    input  logic          seg_wr,
    input  logic          seg_expdn,
    input  logic [AW-1:0] seg_base,
    input  logic [AW-1:0] seg_limit,
    input  logic          tlb_hit,
    input  logic [AW-1:0] tlb_frame,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_paddr,
    output logic          rsp_gp,
    output logic          rsp_miss
);
    localparam int PB = PAGE_OFFSET_BITS;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] paddr;
        logic          gp;
        logic          miss;
    } rsp_t;

    rsp_t st_d, st_q;

    logic          perm_fail;
    logic          bound_fail;
    logic          comp_miss;
    logic [AW-1:0] comp_paddr;
    logic          checks_on;
    logic          gp_hit;

    seg_perm_check u_perm (
        .kind      (req_kind),
        .seg_rd    (seg_rd),
        .seg_wr    (seg_wr),
        .perm_fail (perm_fail)
    );

    seg_bound_check #(.AW(AW), .SW(SW)) u_bound (
        .addr       (req_addr),
        .size       (req_size),
        .base       (seg_base),
        .limit      (seg_limit),
        .expdn      (seg_expdn),
        .bound_fail (bound_fail)
    );

    page_compose #(.AW(AW), .PB(PB)) u_page (
        .paging_on (mode_prot && mode_paging),
        .hit       (tlb_hit),
        .frame     (tlb_frame),
        .addr      (req_addr),
        .paddr     (comp_paddr),
        .miss      (comp_miss)
    );

    always_comb begin
        checks_on  = mode_prot && !(mode_lma && mode_cs64);
        gp_hit     = checks_on && (perm_fail || bound_fail);
        st_d       = '0;
        st_d.valid = req_valid;
        if (req_valid) begin
            if (gp_hit) begin
                st_d.gp = 1'b1;
            end else if (comp_miss) begin
                st_d.miss = 1'b1;
            end else begin
                st_d.paddr = comp_paddr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.valid;
    assign rsp_paddr = st_q.paddr;
    assign rsp_gp    = st_q.gp;
    assign rsp_miss  = st_q.miss;

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_real_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mode_prot) |=>
            (rsp_paddr == $past(req_addr)) && !rsp_gp && !rsp_miss);

    p_long_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_prot && mode_lma && mode_cs64) |=> !rsp_gp);

    p_page_offset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_prot && mode_paging && tlb_hit) |=>
            (rsp_gp || (rsp_paddr[PB-1:0] ==
                ($past(req_addr[PB-1:0]) | $past(tlb_frame[PB-1:0])))));

    p_miss_needs_paging_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(mode_prot && mode_paging)) |=> !rsp_miss);

    p_onehot_fault_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_gp, rsp_miss}));

    p_fault_zero_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_gp || rsp_miss) |-> (rsp_paddr == '0));

endmodule

// File: tb/sim_seg_xlate_check.sv
`timescale 1ns/1ps
module sim_seg_xlate_check;
    localparam int AW = 32;
    localparam int SW = 4;
    localparam int NV = 22;

    typedef struct packed {
        logic [7:0]  req;
        logic [1:0]  kind;
        logic        prot, pg, lma, cs64, rd, wr, ed, hit;
        logic [3:0]  size;
        logic [31:0] addr, base, limit, frame;
        logic        e_gp, e_miss;
        logic [31:0] e_pa;
    } vec_t;

    localparam logic [1:0] KR = 2'b00, KW = 2'b01, KX = 2'b10;
    localparam logic [31:0] FULL = 32'hFFFF_FFFF;

    localparam vec_t VEC [NV] = '{
        // R3 real mode: bad segment and a paging miss are ignored
        '{8'd3, KW, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd4, 32'h1234, 32'h0, 32'h0, 32'h0, 1'b0,1'b0, 32'h1234},
        // R4 both long-mode bits: checks skipped
        '{8'd4, KW, 1'b1,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0, 4'd4, 32'h2000, 32'h0, 32'h0, 32'h0, 1'b0,1'b0, 32'h2000},
        // R4 only one long-mode bit: checks run
        '{8'd4, KW, 1'b1,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0, 4'd4, 32'h2000, 32'h0, FULL, 32'h0, 1'b1,1'b0, 32'h0},
        // R5 write to read-only
        '{8'd5, KW, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, 4'd4, 32'h100, 32'h0, 32'hFFFF, 32'h0, 1'b1,1'b0, 32'h0},
        // R5 read of non-readable
        '{8'd5, KR, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd4, 32'h100, 32'h0, 32'hFFFF, 32'h0, 1'b1,1'b0, 32'h0},
        // R5 fetch from non-readable is allowed
        '{8'd5, KX, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd4, 32'h100, 32'h0, 32'hFFFF, 32'h0, 1'b0,1'b0, 32'h100},
        // R6 end exactly at limit
        '{8'd6, KR, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 4'd4, 32'h0FFC, 32'h0, 32'h1000, 32'h0, 1'b0,1'b0, 32'h0FFC},
        // R6 end one past limit
        '{8'd6, KR, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 4'd4, 32'h0FFD, 32'h0, 32'h1000, 32'h0, 1'b1,1'b0, 32'h0},
        // R7 wrapped expand-up, in the hole
        '{8'd7, KR, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 4'd4, 32'h2000, 32'h8000, 32'h1000, 32'h0, 1'b1,1'b0, 32'h0},
        // R7 wrapped expand-up, above base
        '{8'd7, KR, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 4'd4, 32'h9000, 32'h8000, 32'h1000, 32'h0, 1'b0,1'b0, 32'h9000},
        // R7 wrapped expand-up, below limit
        '{8'd7, KR, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 4'd4, 32'h0F00, 32'h8000, 32'h1000, 32'h0, 1'b0,1'b0, 32'h0F00},
        // R8 wrapped expand-down, address at limit
        '{8'd8, KR, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0, 4'd4, 32'h1000, 32'h8000, 32'h1000, 32'h0, 1'b1,1'b0, 32'h0},
        // R8 wrapped expand-down, inside
        '{8'd8, KR, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0, 4'd4, 32'h4000, 32'h8000, 32'h1000, 32'h0, 1'b0,1'b0, 32'h4000},
        // R8 wrapped expand-down, end reaches base
        '{8'd8, KR, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0, 4'd4, 32'h7FFC, 32'h8000, 32'h1000, 32'h0, 1'b1,1'b0, 32'h0},
        // R9 normal expand-down, inside the hole
        '{8'd9, KR, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0, 4'd4, 32'h2000, 32'h1000, 32'h8000, 32'h0, 1'b1,1'b0, 32'h0},
        // R9 normal expand-down, above limit
        '{8'd9, KR, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0, 4'd4, 32'h9000, 32'h1000, 32'h8000, 32'h0, 1'b0,1'b0, 32'h9000},
        // R9 normal expand-down, below base
        '{8'd9, KR, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0, 4'd4, 32'h0100, 32'h1000, 32'h8000, 32'h0, 1'b0,1'b0, 32'h0100},
        // R10 paging hit: frame OR page offset
        '{8'd10, KR, 1'b1,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b1, 4'd4, 32'h0034_5678, 32'h0, FULL, 32'hABCD_E000, 1'b0,1'b0, 32'hABCD_E678},
        // R11 paging miss
        '{8'd11, KR, 1'b1,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 4'd4, 32'h0034_5678, 32'h0, FULL, 32'h0, 1'b0,1'b1, 32'h0},
        // R12 GP and miss together: GP only
        '{8'd12, KW, 1'b1,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, 4'd4, 32'h0034_5678, 32'h0, FULL, 32'h0, 1'b1,1'b0, 32'h0},
        // R11 paging off with protection on: pass through
        '{8'd11, KR, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 4'd4, 32'h5555, 32'h0, FULL, 32'h0, 1'b0,1'b0, 32'h5555},
        // R6 access running off the top of the address space
        '{8'd6, KR, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 4'd4, 32'hFFFF_FFFE, 32'h0, FULL, 32'h0, 1'b1,1'b0, 32'h0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [SW-1:0] req_size = '0;
    logic [1:0]    req_kind = '0;
    logic          mode_prot = 1'b0, mode_paging = 1'b0, mode_lma = 1'b0, mode_cs64 = 1'b0;
    logic          seg_rd = 1'b0, seg_wr = 1'b0, seg_expdn = 1'b0;
    logic [AW-1:0] seg_base = '0, seg_limit = '0;
    logic          tlb_hit = 1'b0;
    logic [AW-1:0] tlb_frame = '0;
    logic          rsp_valid, rsp_gp, rsp_miss;
    logic [AW-1:0] rsp_paddr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    seg_xlate_check #(.AW(AW), .SW(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_kind(req_kind), .mode_prot(mode_prot),
        .mode_paging(mode_paging), .mode_lma(mode_lma), .mode_cs64(mode_cs64),
        .seg_rd(seg_rd), .seg_wr(seg_wr), .seg_expdn(seg_expdn),
        .seg_base(seg_base), .seg_limit(seg_limit), .tlb_hit(tlb_hit),
        .tlb_frame(tlb_frame), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_gp(rsp_gp), .rsp_miss(rsp_miss)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_valid   = 1'b1;
        req_kind    = v.kind;
        mode_prot   = v.prot;
        mode_paging = v.pg;
        mode_lma    = v.lma;
        mode_cs64   = v.cs64;
        seg_rd      = v.rd;
        seg_wr      = v.wr;
        seg_expdn   = v.ed;
        tlb_hit     = v.hit;
        req_size    = v.size;
        req_addr    = v.addr;
        seg_base    = v.base;
        seg_limit   = v.limit;
        tlb_frame   = v.frame;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", 64'(rsp_valid), 64'd0);
        chk("R1 gp", 64'(rsp_gp), 64'd0);
        chk("R1 miss", 64'(rsp_miss), 64'd0);
        chk("R1 paddr", 64'(rsp_paddr), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 64'({rsp_valid, rsp_gp, rsp_miss}), 64'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            chk($sformatf("R2 valid vec%0d", i), 64'(rsp_valid), 64'd1);
            chk($sformatf("R%0d gp vec%0d", VEC[i].req, i), 64'(rsp_gp), 64'(VEC[i].e_gp));
            chk($sformatf("R%0d miss vec%0d", VEC[i].req, i), 64'(rsp_miss), 64'(VEC[i].e_miss));
            chk($sformatf("R%0d paddr vec%0d", VEC[i].req, i), 64'(rsp_paddr), 64'(VEC[i].e_pa));
        end

        // R2 idle cycle gives no response, even with a faulting setup held
        drive(VEC[7]);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R2 idle valid", 64'(rsp_valid), 64'd0);
        chk("R2 idle faults", 64'({rsp_gp, rsp_miss}), 64'd0);

        // R1 reset mid-stream clears a pending fault response
        drive(VEC[18]);
        @(negedge clk);
        chk("R11 miss before reset", 64'(rsp_miss), 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears", 64'({rsp_valid, rsp_gp, rsp_miss}), 64'd0);
        rst_n = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R2 actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule